// File: doc/BRIEF.md
# TPM FIFO Command Transmit Sequencer

This block sits on the host side of a trusted-platform-module register window. It feeds one command byte stream into the device's byte-wide data FIFO without help from software. It is a master on a single-outstanding register bus. The bus has a request held until acknowledge, a write-enable, an address, 32-bit write data and 32-bit read data. Command bytes arrive from a source over a valid/ready handshake, and the total length is given when the command starts. Only locality 0 of the window is used: the status word sits at offset 0x18 and the data byte at offset 0x24 from a base address set by parameter.

A command begins with a one-cycle `start` pulse. The sequencer first polls status until the device reports it is ready for a command. It then sends the bytes in bursts. Each burst is limited by the credit that the status word advertises. The final byte is always kept out of the bursts and written by itself. This is so the device's "more data expected" flag can be checked once while bytes are still owed and again once the command is complete. When the command is complete, the sequencer writes the execute bit and ends with a `done` pulse carrying a result code.

Every wait on the device is bounded by a cycle limit that restarts whenever progress is made. Back-to-back status polls are spaced by a minimum number of cycles.

Top module: `tpm_cmd_tx_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `bus_req`, `busy`, `done` and `src_ready` are 0 and `err_code` is 0.
- R2: A `start` with `cmd_len` equal to 0 gives `done` one cycle later with `err_code` 3 (length rejected) and makes no bus request.
- R3: No data-register write happens before a status read has returned bit 6 (command ready) set. Status reads are 32-bit reads of offset 0x18.
- R4: The credit is status bits 23:8. Each group of data writes between two status reads holds at most min(credit, remaining-1) bytes, so the last byte always goes alone, after a status read.
- R5: After each burst, status is polled until bit 7 (valid) is set. If bit 3 (expect) is then clear, the command ends with `err_code` 2 (protocol).
- R6: A status read whose credit is 0 does not let data be written. The sequencer keeps polling until the credit is nonzero. It enters the last-byte phase only when one byte remains and the credit is nonzero.
- R7: After the last byte, status is polled until valid. If expect is still set, the command ends with `err_code` 2 and no execute write is made.
- R8: On success, exactly one status write is made, with value 0x00000020 (bit 5, execute), and then `done` rises with `err_code` 0. No other value is ever written to status.
- R9: If any wait goes TIMEOUT_CYC cycles without progress, the command ends with `err_code` 1 (timeout). After any `done`, no further bus request is made.
- R10: Issues of consecutive status reads are at least POLL_GAP cycles apart.
- R11: Once raised, `bus_req` and its address, write-enable and write data stay unchanged until `bus_ack`. Only one request is outstanding at a time.
- R12: A command of length 1 makes exactly one data write and no burst.
- R13: Each data write goes to offset 0x24 with the source byte in `bus_wdata[7:0]`. The bytes arrive in source order, and a byte is taken only when `src_valid` and `src_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command start, honoured when idle |
| cmd_len | input | LEN_W | Command length in bytes, sampled with `start` |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte taken this cycle |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge from the device |
| bus_rdata | input | 32 | Read data, valid while `bus_ack` is high |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 protocol, 3 bad length; valid with `done` |

## Verification
The assertions assume a device that raises `bus_ack` for one cycle and only while `bus_req` is high, with read data valid in that cycle. They also assume `start` arrives only when the sequencer is idle, and that the source byte stays put while offered. The bench meets these with a device model that acknowledges one cycle after it sees each request. Its source offers a byte on every cycle and advances only on a completed handshake. Each new command starts only after the previous `done` has been seen. Device faults are injected only through the status words the model returns: ready withheld, zero credit, expect dropped early, and expect stuck set.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int BUS_DW     = 32;
    localparam int BYTE_W     = 8;
    localparam int CREDIT_W   = 16;
    localparam int CREDIT_LSB = 8;

    localparam int BIT_VALID  = 7;
    localparam int BIT_READY  = 6;
    localparam int BIT_GO     = 5;
    localparam int BIT_MORE   = 3;

    localparam int OFF_STATUS = 'h18;
    localparam int OFF_DATA   = 'h24;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_PROTO   = 2'd2,
        ERR_LEN     = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_DECIDE,
        ST_WAIT_CREDIT,
        ST_BURST,
        ST_WAIT_VALID,
        ST_LAST,
        ST_WAIT_FINAL,
        ST_GO
    } state_e;

    typedef struct packed {
        logic                valid;
        logic                ready;
        logic                more;
        logic [CREDIT_W-1:0] credit;
    } stat_t;

    typedef struct packed {
        logic              we;
        logic              sel_data;
        logic [BUS_DW-1:0] wdata;
    } bus_op_t;

    function automatic stat_t decode_status(input logic [BUS_DW-1:0] w);
        stat_t s;
        s.valid  = w[BIT_VALID];
        s.ready  = w[BIT_READY];
        s.more   = w[BIT_MORE];
        s.credit = w[CREDIT_LSB +: CREDIT_W];
        return s;
    endfunction

    function automatic logic [BUS_DW-1:0] go_word();
        return BUS_DW'(1) << BIT_GO;
    endfunction

endpackage

// File: rtl/tcs_bus_port.sv
module tcs_bus_port
    import tcs_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  bus_op_t           op_in,
    input  logic              ack,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [BUS_DW-1:0] wdata,
    output logic              idle,
    output logic              rsp
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(BASE_ADDR + OFF_STATUS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(BASE_ADDR + OFF_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            we    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else if (req && ack) begin
            req <= 1'b0;
        end else if (!req && issue) begin
            req   <= 1'b1;
            we    <= op_in.we;
            addr  <= op_in.sel_data ? DATA_A : STAT_A;
            wdata <= op_in.wdata;
        end
    end

    assign idle = !req;
    assign rsp  = req && ack;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst) (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(wdata))); // R11
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) issue |-> !req); // R11

endmodule

// File: rtl/tcs_wait_timer.sv
module tcs_wait_timer #(
    parameter int TIMEOUT_CYC = 1000,
    parameter int POLL_GAP    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    input  logic poll_sent,
    output logic expired,
    output logic gap_ok
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    logic [TW-1:0] tmo_cnt;
    logic [GW-1:0] gap_cnt;

    assign expired = tmo_cnt >= TW'(TIMEOUT_CYC);
    assign gap_ok  = gap_cnt >= GW'(POLL_GAP);

    // No-progress counter: cleared on every state change.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tmo_cnt <= '0;
        end else if (active && !expired) begin
            tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    // Spacing counter: saturates at the gap, cleared by each poll issue.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= GW'(POLL_GAP);
        end else if (poll_sent) begin
            gap_cnt <= '0;
        end else if (!gap_ok) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst) restart |=> !expired); // R9
    AST_POLL_SPACED: assert property (@(posedge clk) disable iff (rst) poll_sent |-> gap_ok); // R10

endmodule

// File: rtl/tcs_credit.sv
module tcs_credit
    import tcs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_len,
    input  logic [LEN_W-1:0]    len_in,
    input  logic                load_credit,
    input  logic [CREDIT_W-1:0] credit_in,
    input  logic                start_burst,
    input  logic                byte_sent,
    output logic                rem_one,
    output logic                has_credit,
    output logic                burst_last
);
    localparam int CW = (LEN_W > CREDIT_W) ? LEN_W : CREDIT_W;

    logic [LEN_W-1:0]    rem;
    logic [CREDIT_W-1:0] credit_q;
    logic [CW-1:0]       burst_left;
    logic [CW-1:0]       rem_m1;
    logic [CW-1:0]       cred_w;

    assign rem_m1 = CW'(rem) - 1'b1;
    assign cred_w = CW'(credit_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load_len) begin
            rem <= len_in;
        end else if (byte_sent && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= '0;
        end else if (load_credit) begin
            credit_q <= credit_in;
        end
    end

    // A burst never includes the final byte: it is capped at remaining-1.
    always_ff @(posedge clk) begin
        if (rst) begin
            burst_left <= '0;
        end else if (start_burst) begin
            burst_left <= (cred_w < rem_m1) ? cred_w : rem_m1;
        end else if (byte_sent && burst_left != '0) begin
            burst_left <= burst_left - 1'b1;
        end
    end

    assign rem_one    = rem == LEN_W'(1);
    assign has_credit = credit_q != '0;
    assign burst_last = burst_left == CW'(1);

    AST_BURST_NOT_FINAL: assert property (@(posedge clk) disable iff (rst) (byte_sent && burst_left != '0) |-> (rem > LEN_W'(1))); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) byte_sent |-> (rem != '0)); // R4
    AST_BURST_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst) start_burst |-> (credit_q != '0)); // R6

endmodule

// File: rtl/tpm_cmd_tx_seq.sv
module tpm_cmd_tx_seq
    import tcs_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 0,
    parameter int          LEN_W       = 16,
    parameter int          TIMEOUT_CYC = 125_000_000,
    parameter int          POLL_GAP    = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(BASE_ADDR + OFF_STATUS);

    state_e  state, nxt;
    stat_t   st;
    bus_op_t op;
    err_e    fin_code;
    logic    issue, idle, rsp, fin;
    logic    expired, gap_ok, restart, active, poll_sent;
    logic    load_len, load_credit, start_burst, byte_sent;
    logic    rem_one, has_credit, burst_last;

    assign st = decode_status(bus_rdata);

    tcs_bus_port #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .op_in (op),
        .ack   (bus_ack),
        .req   (bus_req),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .idle  (idle),
        .rsp   (rsp)
    );

    tcs_wait_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .POLL_GAP    (POLL_GAP)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .active    (active),
        .poll_sent (poll_sent),
        .expired   (expired),
        .gap_ok    (gap_ok)
    );

    tcs_credit #(
        .LEN_W (LEN_W)
    ) u_cred (
        .clk         (clk),
        .rst         (rst),
        .load_len    (load_len),
        .len_in      (cmd_len),
        .load_credit (load_credit),
        .credit_in   (st.credit),
        .start_burst (start_burst),
        .byte_sent   (byte_sent),
        .rem_one     (rem_one),
        .has_credit  (has_credit),
        .burst_last  (burst_last)
    );

    assign active    = (state == ST_WAIT_RDY)   || (state == ST_WAIT_CREDIT) ||
                       (state == ST_WAIT_VALID) || (state == ST_WAIT_FINAL);
    assign restart   = (nxt != state);
    assign poll_sent = issue && !op.we;

    always_comb begin
        nxt         = state;
        issue       = 1'b0;
        op          = '0;
        src_ready   = 1'b0;
        load_len    = 1'b0;
        load_credit = 1'b0;
        start_burst = 1'b0;
        byte_sent   = 1'b0;
        fin         = 1'b0;
        fin_code    = ERR_NONE;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cmd_len == '0) begin
                        fin      = 1'b1;
                        fin_code = ERR_LEN;
                    end else begin
                        load_len = 1'b1;
                        nxt      = ST_WAIT_RDY;
                    end
                end
            end
            ST_WAIT_RDY: begin
                if (rsp) begin
                    if (st.ready) begin
                        load_credit = 1'b1;
                        nxt         = ST_DECIDE;
                    end else if (expired) begin
                        fin      = 1'b1;
                        fin_code = ERR_TIMEOUT;
                    end
                end else if (idle && gap_ok) begin
                    issue = 1'b1;
                end
            end
            ST_DECIDE: begin
                if (!has_credit) begin
                    nxt = ST_WAIT_CREDIT;
                end else if (rem_one) begin
                    nxt = ST_LAST;
                end else begin
                    start_burst = 1'b1;
                    nxt         = ST_BURST;
                end
            end
            ST_WAIT_CREDIT: begin
                if (rsp) begin
                    if (st.credit != '0) begin
                        load_credit = 1'b1;
                        nxt         = ST_DECIDE;
                    end else if (expired) begin
                        fin      = 1'b1;
                        fin_code = ERR_TIMEOUT;
                    end
                end else if (idle && gap_ok) begin
                    issue = 1'b1;
                end
            end
            ST_BURST, ST_LAST: begin
                if (rsp) begin
                    byte_sent = 1'b1;
                    if (state == ST_LAST) begin
                        nxt = ST_WAIT_FINAL;
                    end else if (burst_last) begin
                        nxt = ST_WAIT_VALID;
                    end
                end else if (idle && src_valid) begin
                    issue       = 1'b1;
                    src_ready   = 1'b1;
                    op.we       = 1'b1;
                    op.sel_data = 1'b1;
                    op.wdata    = {{(BUS_DW-BYTE_W){1'b0}}, src_data};
                end
            end
            ST_WAIT_VALID: begin
                if (rsp) begin
                    if (st.valid) begin
                        if (!st.more) begin
                            fin      = 1'b1;
                            fin_code = ERR_PROTO;
                        end else begin
                            load_credit = 1'b1;
                            nxt         = ST_DECIDE;
                        end
                    end else if (expired) begin
                        fin      = 1'b1;
                        fin_code = ERR_TIMEOUT;
                    end
                end else if (idle && gap_ok) begin
                    issue = 1'b1;
                end
            end
            ST_WAIT_FINAL: begin
                if (rsp) begin
                    if (st.valid) begin
                        if (st.more) begin
                            fin      = 1'b1;
                            fin_code = ERR_PROTO;
                        end else begin
                            nxt = ST_GO;
                        end
                    end else if (expired) begin
                        fin      = 1'b1;
                        fin_code = ERR_TIMEOUT;
                    end
                end else if (idle && gap_ok) begin
                    issue = 1'b1;
                end
            end
            ST_GO: begin
                if (rsp) begin
                    fin      = 1'b1;
                    fin_code = ERR_NONE;
                end else if (idle) begin
                    issue    = 1'b1;
                    op.we    = 1'b1;
                    op.wdata = go_word();
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (fin) begin
            nxt = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            state <= nxt;
            done  <= fin;
            if (fin) begin
                err_code <= fin_code;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    AST_GO_ONLY: assert property (@(posedge clk) disable iff (rst) (bus_req && bus_we && bus_addr == STAT_A) |-> (bus_wdata == go_word())); // R8
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst) (!busy && start && cmd_len == '0) |=> (done && err_code == ERR_LEN)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
    AST_SRC_HANDSHAKE: assert property (@(posedge clk) disable iff (rst) src_ready |-> src_valid); // R13
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !bus_req); // R9

endmodule

// File: tb/sim_tpm_cmd_tx_seq.sv
module sim_tpm_cmd_tx_seq;

    localparam int TMO    = 200;
    localparam int GAP    = 3;
    localparam logic [15:0] STAT_A = 16'h0018;
    localparam logic [15:0] DATA_A = 16'h0024;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] credit;
        logic [7:0]  zc;
        logic [7:0]  nr;
        logic [3:0]  fault;
        logic [1:0]  code;
        logic [15:0] exp_rx;
    } vec_t;

    // fault: 0 none, 1 never ready, 2 expect drops early, 3 expect stuck, 4 credit always 0
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{16'd10, 16'd4,  8'd0, 8'd2, 4'd0, 2'd0, 16'd10},
        '{16'd1,  16'd3,  8'd0, 8'd0, 4'd0, 2'd0, 16'd1},
        '{16'd2,  16'd1,  8'd2, 8'd1, 4'd0, 2'd0, 16'd2},
        '{16'd7,  16'd16, 8'd0, 8'd0, 4'd0, 2'd0, 16'd7},
        '{16'd5,  16'd2,  8'd0, 8'd0, 4'd2, 2'd2, 16'd2},
        '{16'd3,  16'd8,  8'd0, 8'd0, 4'd3, 2'd2, 16'd3},
        '{16'd4,  16'd2,  8'd0, 8'd0, 4'd1, 2'd1, 16'd0},
        '{16'd6,  16'd3,  8'd0, 8'd0, 4'd4, 2'd1, 16'd0},
        '{16'd9,  16'd1,  8'd3, 8'd0, 4'd0, 2'd0, 16'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] cmd_len = '0;
    logic        src_valid = 1'b0;
    logic [7:0]  src_data;
    logic        src_ready;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        busy, done;
    logic [1:0]  err_code;

    always #4 clk = ~clk;

    tpm_cmd_tx_seq #(
        .ADDR_W      (16),
        .BASE_ADDR   (0),
        .LEN_W       (16),
        .TIMEOUT_CYC (TMO),
        .POLL_GAP    (GAP)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_len   (cmd_len),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .err_code  (err_code)
    );

    int checks = 0;
    int fails  = 0;

    // configuration driven by the test tasks
    logic cfg_load = 1'b0;
    int   cfg_len = 0, cfg_credit = 0, cfg_zc = 0, cfg_nr = 0, cfg_fault = 0, cur_vec = 0;

    // device model state
    int   nr_left, zc_left, rx_cnt, grp, go_seen, bad_wr, early_wr, grp_viol;
    int   gap_viol, hold_viol, txn, last_rd, cyc;
    bit   have_rd, saw_ready, pend;
    logic [15:0] h_addr;
    logic        h_we;
    logic [31:0] h_wd;
    logic [7:0]  rx_mem [64];
    int   src_idx;

    function automatic logic [7:0] pat(input int v, input int i);
        return 8'((i * 7 + v * 13 + 1) % 256);
    endfunction

    assign src_data = pat(cur_vec, src_idx);

    function automatic logic [31:0] stat_word();
        logic        rdy, more;
        logic [15:0] cr;
        rdy  = (nr_left == 0) && (cfg_fault != 1);
        cr   = (cfg_fault == 4 || !rdy || zc_left != 0) ? 16'd0 : 16'(cfg_credit);
        if (cfg_fault == 3)      more = 1'b1;
        else if (cfg_fault == 2) more = (rx_cnt == 0);
        else                     more = (rx_cnt < cfg_len);
        return {8'h00, cr, 1'b1, rdy, 2'b00, more, 3'b000};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || cfg_load) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            pend      <= 1'b0;
            nr_left   <= cfg_nr;
            zc_left   <= cfg_zc;
            rx_cnt    <= 0;
            grp       <= 0;
            go_seen   <= 0;
            bad_wr    <= 0;
            early_wr  <= 0;
            grp_viol  <= 0;
            gap_viol  <= 0;
            hold_viol <= 0;
            txn       <= 0;
            have_rd   <= 1'b0;
            saw_ready <= 1'b0;
            src_idx   <= 0;
        end else begin
            if (src_valid && src_ready) src_idx <= src_idx + 1;
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack) begin
                bus_rdata <= stat_word();
                pend      <= 1'b1;
                h_addr    <= bus_addr;
                h_we      <= bus_we;
                h_wd      <= bus_wdata;
            end
            if (pend && !bus_req) hold_viol <= hold_viol + 1;
            if (pend && bus_req && (bus_addr != h_addr || bus_we != h_we || bus_wdata != h_wd))
                hold_viol <= hold_viol + 1;
            if (bus_req && bus_ack) begin
                pend <= 1'b0;
                txn  <= txn + 1;
                if (!bus_we) begin
                    if (bus_addr != STAT_A) bad_wr <= bad_wr + 1;
                    grp <= 0;
                    if (bus_rdata[6]) saw_ready <= 1'b1;
                    if (nr_left > 0) nr_left <= nr_left - 1;
                    else if (zc_left > 0) zc_left <= zc_left - 1;
                    if (have_rd && (cyc - last_rd) < GAP) gap_viol <= gap_viol + 1;
                    last_rd <= cyc;
                    have_rd <= 1'b1;
                end else if (bus_addr == DATA_A) begin
                    if (!saw_ready) early_wr <= early_wr + 1;
                    if (grp >= cfg_credit) grp_viol <= grp_viol + 1;
                    if (rx_cnt + 1 == cfg_len && grp != 0) grp_viol <= grp_viol + 1;
                    rx_mem[rx_cnt[5:0]] <= bus_wdata[7:0];
                    rx_cnt <= rx_cnt + 1;
                    grp    <= grp + 1;
                end else if (bus_addr == STAT_A && bus_wdata == 32'h0000_0020) begin
                    go_seen <= go_seen + 1;
                end else begin
                    bad_wr <= bad_wr + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int v, input int len, input int cr, input int zc, input int nr, input int f);
        @(negedge clk);
        cur_vec = v; cfg_len = len; cfg_credit = cr; cfg_zc = zc; cfg_nr = nr; cfg_fault = f;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run_vec(input int v);
        vec_t  t;
        int    el, mism, txn_done;
        bit    got;
        logic [1:0] code;
        string tag;
        t = VEC[v];
        load_cfg(v, int'(t.len), int'(t.credit), int'(t.zc), int'(t.nr), int'(t.fault));
        cmd_len   = t.len;
        src_valid = 1'b1;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        el = 1; got = 1'b0; code = 2'd0;
        while (!got && el < 3000) begin
            if (done) begin
                got  = 1'b1;
                code = err_code;
            end else begin
                @(negedge clk);
                el++;
            end
        end
        case (int'(t.fault))
            0: tag = "R8";
            2: tag = "R5";
            3: tag = "R7";
            default: tag = "R9";
        endcase
        check(got, tag, int'(got), 1);
        check(code == t.code, tag, int'(code), int'(t.code));
        check(rx_cnt == int'(t.exp_rx), (t.len == 16'd1) ? "R12" : "R4", rx_cnt, int'(t.exp_rx));
        mism = 0;
        for (int i = 0; i < rx_cnt && i < 64; i++) if (rx_mem[i] != pat(v, i)) mism++;
        check(mism == 0, "R13", mism, 0);
        check(go_seen == ((t.code == 2'd0) ? 1 : 0), "R8", go_seen, (t.code == 2'd0) ? 1 : 0);
        check(grp_viol == 0, "R4", grp_viol, 0);
        check(early_wr == 0, "R3", early_wr, 0);
        check(gap_viol == 0, "R10", gap_viol, 0);
        check(hold_viol == 0, "R11", hold_viol, 0);
        check(bad_wr == 0, "R13", bad_wr, 0);
        if (t.code == 2'd1) check(el >= TMO, "R9", el, TMO);
        if (t.zc != 8'd0) check(zc_left == 0 && code == 2'd0, "R6", zc_left, 0);
        txn_done = txn;
        src_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(txn == txn_done && !bus_req, "R9", txn, txn_done);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        repeat (145000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int txn0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!bus_req && !busy && !done && !src_ready && err_code == 2'd0, "R1",
              int'({bus_req, busy, done, src_ready}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && !busy && !done && !src_ready && err_code == 2'd0, "R1",
              int'({bus_req, busy, done, src_ready}), 0);

        // R2: zero length rejected
        load_cfg(0, 0, 4, 0, 0, 0);
        txn0 = txn;
        cmd_len = 16'd0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && err_code == 2'd3, "R2", int'(err_code), 3);
        check(!bus_req && !busy, "R2", int'(bus_req), 0);
        repeat (4) @(negedge clk);
        check(txn == txn0 && !bus_req, "R2", txn, txn0);

        for (int v = 0; v < NV; v++) run_vec(v);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule